// File: doc/BRIEF.md
# Event Counter with Decade Timer and Event Alarm

This block counts events on an asynchronous input. Each rising edge of `evt_in` is passed through a two-flop synchronizer and an edge detector. The edge then advances a six-digit packed BCD counter, which wraps from 999999 to 000000.

Software reaches all state through a byte register port. A write is taken on the clock edge while `we` is high. Reads are combinational from `addr`.

Two sticky flags are raised by the counter:
- The timer flag is set on the carry out of a chosen decade.
- The alarm flag is set when an event brings the count to a programmed BCD value.

Each flag can be routed to the active-low interrupt pin `int_n` by its own enable. A stop bit makes the counter ignore events. A hold bit freezes the value that reads of the count return, while counting goes on underneath.

Register map:

| Address | Contents |
|---|---|
| 0x00 | Control: bit0 timer flag, bit1 alarm flag, bit6 hold, bit7 stop; other bits read 0 |
| 0x01 | Count digits 1:0 |
| 0x02 | Count digits 3:2 |
| 0x03 | Count digits 5:4 |
| 0x08 | Alarm control |
| 0x09 to 0x0B | Alarm value, same digit layout as the count |
| Others | Read 0 |

In every count and alarm byte, the low nibble holds the lower digit.

Alarm control bits at 0x08:
- bits 2:0: timer code
- bit 3: timer interrupt enable
- bits 5:4: event-alarm code
- bit 6: timer-alarm enable, stored and read back only
- bit 7: alarm interrupt enable

Top module: `evt_counter_alarm`

## Requirements
- R1: After reset every register reads 0x00 and `int_n` is high.
- R2: Each rising edge of `evt_in` adds one to the BCD count, with a carry between digits. The count wraps from 999999 to 000000. The new count is visible three clock edges after the input rises.
- R3: While control bit 7 (stop) is 1, events leave the count unchanged.
- R4: Setting control bit 6 (hold) makes reads of 0x01 to 0x03 return the count as it was when hold was written. Counting continues, and the live count reads back once hold is cleared.
- R5: Timer code 001 sets the timer flag (control bit0) on every event. Code 010 sets it on the carry out of digit 1, code 011 on the carry out of digit 3, and code 100 on the wrap of all six digits. Codes 000, 101 and 110 never set it.
- R6: Timer code 111 makes each event advance every digit by one, modulo ten and independently of the others. The timer flag is not set in this mode.
- R7: With event-alarm code 01, an event that makes the count equal to the alarm value sets the alarm flag (control bit1). Codes 00, 10 and 11 never set it.
- R8: `int_n` is low exactly when the timer flag and timer interrupt enable (bit3) are both set, or when the alarm flag and alarm interrupt enable (bit7) are both set.
- R9: Both flags stay set until a write to 0x00 clears them. If a flag is set by an event in the same cycle as the write, the event wins.
- R10: Writes to 0x01 to 0x03 load the count digits. A load takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Asynchronous event input |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| int_n | output | 1 | Active-low interrupt |

## Verification
A wrong carry or digit update shows at the count bytes three edges after the event edge. The same fault often shows at once at `int_n` as a missing or spurious timer flag, because the flag and the count update on the same edge. A corrupted alarm compare, or a flag that clears itself, is seen on the next read of 0x00 and on `int_n` without delay. A broken hold capture is visible on the first read of a count byte after hold is set.

// File: rtl/evt_counter_alarm.sv
module evt_counter_alarm #(
  parameter int DIGITS = 6,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_in,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          int_n
);
  localparam int CW    = 4 * DIGITS;
  localparam int BYTES = DIGITS / 2;
  localparam int A_CTL = 0;
  localparam int A_CNT = 1;
  localparam int A_ACT = 8;
  localparam int A_ALM = 9;

  logic [1:0]    sync;
  logic          evt_d, stop, hold, tflag, aflag;
  logic [7:0]    actl;
  logic [CW-1:0] cnt, cap, alm, cnt_inc;
  logic [DIGITS:0] cy;
  logic          evt_rise, cnt_wr, evt_ok, test_md, tmr_hit, alm_hit;

  assign evt_rise = sync[1] & ~evt_d;
  assign cnt_wr   = we && addr >= AW'(A_CNT) && addr < AW'(A_CNT + BYTES);
  assign evt_ok   = evt_rise & ~stop & ~cnt_wr;
  assign test_md  = actl[2:0] == 3'b111;
  assign cy[0]    = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    logic       step;
    assign d    = cnt[4*i +: 4];
    assign step = test_md | cy[i];
    assign cnt_inc[4*i +: 4] = step ? ((d >= 4'd9) ? 4'd0 : 4'(d + 4'd1)) : d;
    assign cy[i+1] = cy[i] & (d == 4'd9);
  end

  always_comb begin
    case (actl[2:0])
      3'b001:  tmr_hit = 1'b1;
      3'b010:  tmr_hit = cy[2];
      3'b011:  tmr_hit = cy[4];
      3'b100:  tmr_hit = cy[DIGITS];
      default: tmr_hit = 1'b0;
    endcase
  end

  assign alm_hit = (actl[5:4] == 2'b01) && (cnt_inc == alm);
  assign int_n   = ~((tflag & actl[3]) | (aflag & actl[7]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      evt_d <= 1'b0;
      stop  <= 1'b0;
      hold  <= 1'b0;
      tflag <= 1'b0;
      aflag <= 1'b0;
      actl  <= '0;
      cnt   <= '0;
      cap   <= '0;
      alm   <= '0;
    end else begin
      sync  <= {sync[0], evt_in};
      evt_d <= sync[1];
      if (!hold) cap <= cnt;
      if (evt_ok) cnt <= cnt_inc;
      if (we) begin
        if (addr == AW'(A_CTL)) begin
          stop  <= wdata[7];
          hold  <= wdata[6];
          tflag <= wdata[0];
          aflag <= wdata[1];
        end
        if (addr == AW'(A_ACT)) actl <= wdata;
        for (int b = 0; b < BYTES; b++) begin
          if (addr == AW'(A_CNT + b)) cnt[8*b +: 8] <= wdata;
          if (addr == AW'(A_ALM + b)) alm[8*b +: 8] <= wdata;
        end
      end
      if (evt_ok && tmr_hit && !test_md) tflag <= 1'b1;
      if (evt_ok && alm_hit) aflag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTL)) rdata = {stop, hold, 4'b0, aflag, tflag};
    if (addr == AW'(A_ACT)) rdata = actl;
    for (int b = 0; b < BYTES; b++) begin
      if (addr == AW'(A_CNT + b)) rdata = hold ? cap[8*b +: 8] : cnt[8*b +: 8];
      if (addr == AW'(A_ALM + b)) rdata = alm[8*b +: 8];
    end
  end
endmodule

// File: rtl/evt_counter_alarm_chk.sv
module evt_counter_alarm_chk #(
  parameter int CW = 24,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          evt_rise,
  input logic          stop,
  input logic          hold,
  input logic          tflag,
  input logic          aflag,
  input logic [7:0]    actl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic          int_n
);
  logic ctl_wr;
  assign ctl_wr = we && addr == '0;

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !we |=> $stable(cnt)); // R3
  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cap)); // R4
  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we && !evt_rise |=> $stable(cnt)); // R2
  AST_TFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tflag && !ctl_wr |=> tflag); // R9
  AST_AFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    aflag && !ctl_wr |=> aflag); // R9
  AST_NO_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    actl[2:0] == 3'b000 && !we |=> !$rose(tflag)); // R5
  AST_QUIET_INT: assert property (@(posedge clk) disable iff (!rst_n)
    !tflag && !aflag |-> int_n); // R8
endmodule

bind evt_counter_alarm evt_counter_alarm_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .evt_rise(evt_rise),
  .stop(stop), .hold(hold), .tflag(tflag), .aflag(aflag), .actl(actl),
  .cnt(cnt), .cap(cap), .int_n(int_n)
);

// File: tb/evt_counter_alarm_test.sv
module evt_counter_alarm_test;
  logic       clk = 1'b0, rst_n = 1'b0, evt_in = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  evt_counter_alarm uut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .int_n(int_n));

  // {timer code, start count, expected count, expected timer flag}
  localparam logic [51:0] VEC [12] = '{
    {3'b001, 24'h000000, 24'h000001, 1'b1},
    {3'b010, 24'h000098, 24'h000099, 1'b0},
    {3'b010, 24'h000099, 24'h000100, 1'b1},
    {3'b011, 24'h009999, 24'h010000, 1'b1},
    {3'b011, 24'h000999, 24'h001000, 1'b0},
    {3'b100, 24'h999999, 24'h000000, 1'b1},
    {3'b100, 24'h099999, 24'h100000, 1'b0},
    {3'b000, 24'h000099, 24'h000100, 1'b0},
    {3'b101, 24'h999999, 24'h000000, 1'b0},
    {3'b110, 24'h009999, 24'h010000, 1'b0},
    {3'b111, 24'h123459, 24'h234560, 1'b0},
    {3'b111, 24'h999999, 24'h000000, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic load(logic [23:0] v);
    wr(4'h1, v[7:0]); wr(4'h2, v[15:8]); wr(4'h3, v[23:16]);
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [7:0] b;
    rd(4'h1, b); v[7:0] = b;
    rd(4'h2, b); v[15:8] = b;
    rd(4'h3, b); v[23:16] = b;
  endtask

  task automatic pulse();
    @(negedge clk); evt_in = 1'b1;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    chk("R1 int_n", {31'b0, int_n}, 1);
    rst_n = 1'b1;
    rd(4'h0, b); chk("R1 ctrl", {24'b0, b}, 0);
    rd(4'h8, b); chk("R1 alarm ctrl", {24'b0, b}, 0);
    rd_cnt(c);   chk("R1 count", {8'b0, c}, 0);
    chk("R1 int_n after reset", {31'b0, int_n}, 1);

    for (int i = 0; i < 12; i++) begin
      wr(4'h8, {4'b0000, 1'b1, VEC[i][51:49]});
      wr(4'h0, 8'h00);
      load(VEC[i][48:25]);
      pulse();
      rd_cnt(c); chk("R2/R6 count step", {8'b0, c}, {8'b0, VEC[i][24:1]});
      rd(4'h0, b); chk("R5/R6 timer flag", {31'b0, b[0]}, {31'b0, VEC[i][0]});
      chk("R8 int_n timer", {31'b0, int_n}, {31'b0, ~VEC[i][0]});
    end

    // R8: flag set without interrupt enable
    wr(4'h8, 8'h01); wr(4'h0, 8'h00); load(24'h000000); pulse();
    rd(4'h0, b); chk("R5 flag without enable", {31'b0, b[0]}, 1);
    chk("R8 int_n masked", {31'b0, int_n}, 1);

    // R3: stop ignores events
    wr(4'h8, 8'h00); load(24'h000042); wr(4'h0, 8'h80); pulse();
    rd_cnt(c); chk("R3 stopped", {8'b0, c}, 32'h42);
    wr(4'h0, 8'h00); pulse();
    rd_cnt(c); chk("R3 resumed", {8'b0, c}, 32'h43);

    // R4: hold freezes readout
    load(24'h000010); wr(4'h0, 8'h40); pulse(); pulse();
    rd_cnt(c); chk("R4 held", {8'b0, c}, 32'h10);
    wr(4'h0, 8'h00);
    rd_cnt(c); chk("R4 released", {8'b0, c}, 32'h12);

    // R7: event alarm
    wr(4'h9, 8'h05); wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h8, 8'h90); wr(4'h0, 8'h00); load(24'h000003); pulse();
    rd(4'h0, b); chk("R7 no match", {31'b0, b[1]}, 0);
    pulse();
    rd(4'h0, b); chk("R7 match", {31'b0, b[1]}, 1);
    chk("R8 int_n alarm", {31'b0, int_n}, 0);
    pulse();
    rd(4'h0, b); chk("R9 alarm flag sticky", {31'b0, b[1]}, 1);
    wr(4'h0, 8'h00);
    rd(4'h0, b); chk("R9 alarm flag cleared", {31'b0, b[1]}, 0);
    chk("R8 int_n released", {31'b0, int_n}, 1);

    wr(4'h8, 8'h10); load(24'h000004); pulse();
    rd(4'h0, b); chk("R7 flag without enable", {31'b0, b[1]}, 1);
    chk("R8 alarm masked", {31'b0, int_n}, 1);

    wr(4'h8, 8'hB0); wr(4'h0, 8'h00); load(24'h000004); pulse();
    rd(4'h0, b); chk("R7 code 11 ignored", {31'b0, b[1]}, 0);
    chk("R8 int_n code 11", {31'b0, int_n}, 1);

    // R10: load readback
    load(24'h987654);
    rd_cnt(c); chk("R10 load", {8'b0, c}, 32'h987654);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule